// File: doc/BRIEF.md
# Cascadable 24-Channel PWM LED Driver with Global Dimming

This block drives 24 LED channels, grouped as eight pixels of red, green and blue, from a serial stream that enters on a data line qualified by a shift enable. A 288-bit shift register collects twelve bits per channel. Each bit that leaves the far end of the register is presented on a data output, together with one-clock-delayed copies of the shift enable, latch and mode lines. Several drivers can therefore be wired in a chain and filled by a single upstream source. The source shifts the bits for the farthest driver first.

A rising edge on the latch line commits the shift register in one cycle. When the mode line is low, the whole register becomes the new grayscale frame. When it is high, the low 32 bits become the configuration: a 7-bit global brightness and three 8-bit drive-current codes, one per colour group. Each channel's output is a PWM waveform set by a free-running 12-bit counter. All channels are gated by a brightness enable that is spread over 128 PWM periods by an overflowing accumulator. At 60 frames per second the pattern repeats once per frame.

Top module: `ledChainDriver`

## Requirements
- R1: After reset, all channel outputs, serOut and the forwarded lines are low, every grayscale value is 0, the brightness is 127, and each current code reads 0x80.
- R2: On every clock with shiftEn high, serIn enters bit 0 of the shift register. In the same cycle serOut takes the bit that entered 288 strobes earlier, and it holds its value while shiftEn is low. shiftEnOut, latchOut and cfgSelOut repeat their inputs one clock later.
- R3: Channel p takes register bits [12p+11:12p], with the most significant bit shifted first, so the last 12 bits shifted in land on channel 0. Channel p belongs to pixel p/3, and its colour is red, green or blue for p mod 3 = 0, 1 or 2.
- R4: A rising latch edge with cfgSel low replaces all 24 grayscale values in one clock. Shifting without a latch edge leaves the outputs unchanged.
- R5: A rising latch edge with cfgSel high loads the brightness from bits [6:0] and the red, green and blue current codes from bits [15:8], [23:16] and [31:24], and leaves the grayscale untouched. A grayscale load leaves these settings untouched.
- R6: A 12-bit counter starts at 0 after reset and counts every clock. One clock after each count c, channel p is high exactly when c is below its value and the brightness gate is open. A value of 0 never lights the channel, and 4095 lights it for 4095 of every 4096 clocks.
- R7: The brightness N takes effect at a PWM period boundary. A 7-bit accumulator that resets to all ones adds N once per period, and the gate is open for a period exactly when that addition carries. The gate opens in N of every 128 periods, and in N/16 of any 8 consecutive periods when N is a multiple of 16.
- R8: With brightness 0, every channel stays dark whatever its grayscale value.
- R9: With brightness 64, open and closed periods alternate, so no two consecutive periods are both open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for shifting and PWM |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftEn | input | 1 | Qualifies serIn for one shift |
| serIn | input | 1 | Serial data in |
| latchIn | input | 1 | Rising edge commits the shift register |
| cfgSel | input | 1 | Low: grayscale load; high: configuration load |
| serOut | output | 1 | Serial data to the next driver |
| shiftEnOut | output | 1 | shiftEn delayed one clock |
| latchOut | output | 1 | latchIn delayed one clock |
| cfgSelOut | output | 1 | cfgSel delayed one clock |
| ledOn | output | 24 | Gated PWM enable per channel |
| redCurrent | output | 8 | Stored red-group current code |
| greenCurrent | output | 8 | Stored green-group current code |
| blueCurrent | output | 8 | Stored blue-group current code |

## Verification
A corrupted grayscale register shows up on one channel within one 4096-clock PWM period, as a duty cycle that differs from the value loaded. A slipped or misordered shift register shows up as a permuted channel pattern after the next latch, and as misplaced bits on serOut 288 strobes later. A faulty brightness accumulator only shows up across several periods, as the wrong count of open periods or two adjacent open periods at brightness 64. For that reason the bench watches eight consecutive periods.

// File: rtl/ledChainPkg.sv
package ledChainPkg;

  // Strobes issued by the control unit to the datapath each clock.
  typedef struct packed {
    logic shift;     // take one serial bit
    logic loadGray;  // commit shift register to grayscale
    logic loadCfg;   // commit low bits to configuration
    logic wrap;      // last count of a PWM period
  } ctrlStrobes_t;

endpackage

// File: rtl/ledChainCtrl.sv
module ledChainCtrl
  import ledChainPkg::*;
#(
  parameter int GRAY_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 shiftEn,
  input  logic                 latchIn,
  input  logic                 cfgSel,
  output ctrlStrobes_t         strobes,
  output logic [GRAY_BITS-1:0] pwmCount,
  output logic                 shiftEnOut,
  output logic                 latchOut,
  output logic                 cfgSelOut
);

  localparam logic [GRAY_BITS-1:0] COUNT_MAX = '1;

  logic latchPrev;
  logic latchRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchPrev  <= 1'b0;
      pwmCount   <= '0;
      shiftEnOut <= 1'b0;
      latchOut   <= 1'b0;
      cfgSelOut  <= 1'b0;
    end else begin
      latchPrev  <= latchIn;
      pwmCount   <= pwmCount + 1'b1;
      shiftEnOut <= shiftEn;
      latchOut   <= latchIn;
      cfgSelOut  <= cfgSel;
    end
  end

  always_comb begin
    latchRise        = latchIn & ~latchPrev;
    strobes.shift    = shiftEn;
    strobes.loadGray = latchRise & ~cfgSel;
    strobes.loadCfg  = latchRise & cfgSel;
    strobes.wrap     = (pwmCount == COUNT_MAX);
  end

  assert_wrap_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (pwmCount == '0))
    else $error("PWM counter did not restart after its last count");

  assert_load_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadGray || strobes.loadCfg) |=> !(strobes.loadGray || strobes.loadCfg))
    else $error("load strobe lasted more than one clock");

  assert_fwd_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    latchIn |=> latchOut)
    else $error("latch not forwarded");

endmodule

// File: rtl/ledChainPdm.sv
module ledChainPdm #(
  parameter int PDM_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrap,
  input  logic [PDM_BITS-1:0] level,
  output logic                gate
);

  logic [PDM_BITS-1:0] acc;
  logic [PDM_BITS-1:0] levelAct;
  logic [PDM_BITS:0]   sum;

  always_comb begin
    sum  = {1'b0, acc} + {1'b0, levelAct};
    gate = sum[PDM_BITS];
  end

  // Level and accumulator change only at a period boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '1;
      levelAct <= '1;
    end else if (wrap) begin
      acc      <= sum[PDM_BITS-1:0];
      levelAct <= level;
    end
  end

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(acc))
    else $error("dither accumulator moved inside a period");

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(levelAct))
    else $error("brightness changed inside a period");

endmodule

// File: rtl/ledChainData.sv
module ledChainData
  import ledChainPkg::*;
#(
  parameter int PORTS     = 24,
  parameter int GRAY_BITS = 12,
  parameter int PDM_BITS  = 7,
  parameter int CUR_BITS  = 8,
  parameter int GROUPS    = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  input  logic                             serIn,
  input  logic [GRAY_BITS-1:0]             pwmCount,
  input  logic                             pdmGate,
  output logic                             serOut,
  output logic [PORTS-1:0]                 ledOn,
  output logic [PDM_BITS-1:0]              pdmLevel,
  output logic [GROUPS-1:0][CUR_BITS-1:0]  currents
);

  localparam int SHIFT_LEN = PORTS * GRAY_BITS;
  localparam int PDM_FIELD = ((PDM_BITS + 7) / 8) * 8;
  localparam logic [CUR_BITS-1:0] CUR_RESET = CUR_BITS'(1) << (CUR_BITS - 1);

  logic [SHIFT_LEN-1:0]              shiftReg;
  logic [PORTS-1:0][GRAY_BITS-1:0]   grayReg;
  logic [PORTS-1:0]                  litNext;

  // Serial path: one bit per strobe, oldest bit forwarded.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      serOut   <= 1'b0;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[SHIFT_LEN-2:0], serIn};
      serOut   <= shiftReg[SHIFT_LEN-1];
    end
  end

  // Grayscale commit: whole frame at once.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grayReg <= '0;
    end else if (strobes.loadGray) begin
      grayReg <= shiftReg;
    end
  end

  // Configuration commit: brightness plus one current code per colour.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdmLevel <= '1;
      for (int g = 0; g < GROUPS; g++) currents[g] <= CUR_RESET;
    end else if (strobes.loadCfg) begin
      pdmLevel <= shiftReg[PDM_BITS-1:0];
      for (int g = 0; g < GROUPS; g++)
        currents[g] <= shiftReg[PDM_FIELD + g*CUR_BITS +: CUR_BITS];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign litNext[p] = (pwmCount < grayReg[p]);

    assert_zero_dark_R6: assert property (@(posedge clk) disable iff (!rstN)
      (grayReg[p] == '0) |=> !ledOn[p])
      else $error("channel lit with a zero value");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ledOn <= '0;
    else       ledOn <= litNext & {PORTS{pdmGate}};
  end

  assert_gray_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadGray |=> $stable(grayReg))
    else $error("grayscale changed without a load");

  assert_cfg_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCfg |=> ($stable(pdmLevel) && $stable(currents)))
    else $error("configuration changed without a load");

  assert_serout_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(serOut))
    else $error("serial output moved without a strobe");

endmodule

// File: rtl/ledChainDriver.sv
module ledChainDriver
  import ledChainPkg::*;
#(
  parameter int PORTS     = 24,
  parameter int GRAY_BITS = 12,
  parameter int PDM_BITS  = 7,
  parameter int CUR_BITS  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shiftEn,
  input  logic                serIn,
  input  logic                latchIn,
  input  logic                cfgSel,
  output logic                serOut,
  output logic                shiftEnOut,
  output logic                latchOut,
  output logic                cfgSelOut,
  output logic [PORTS-1:0]    ledOn,
  output logic [CUR_BITS-1:0] redCurrent,
  output logic [CUR_BITS-1:0] greenCurrent,
  output logic [CUR_BITS-1:0] blueCurrent
);

  localparam int GROUPS = 3;

  ctrlStrobes_t                    strobes;
  logic [GRAY_BITS-1:0]            pwmCount;
  logic [PDM_BITS-1:0]             pdmLevel;
  logic                            pdmGate;
  logic [GROUPS-1:0][CUR_BITS-1:0] currents;

  ledChainCtrl #(.GRAY_BITS(GRAY_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .latchIn(latchIn), .cfgSel(cfgSel),
    .strobes(strobes), .pwmCount(pwmCount),
    .shiftEnOut(shiftEnOut), .latchOut(latchOut), .cfgSelOut(cfgSelOut)
  );

  ledChainData #(
    .PORTS(PORTS), .GRAY_BITS(GRAY_BITS), .PDM_BITS(PDM_BITS),
    .CUR_BITS(CUR_BITS), .GROUPS(GROUPS)
  ) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serIn(serIn),
    .pwmCount(pwmCount), .pdmGate(pdmGate), .serOut(serOut),
    .ledOn(ledOn), .pdmLevel(pdmLevel), .currents(currents)
  );

  ledChainPdm #(.PDM_BITS(PDM_BITS)) pdm (
    .clk(clk), .rstN(rstN), .wrap(strobes.wrap), .level(pdmLevel), .gate(pdmGate)
  );

  assign redCurrent   = currents[0];
  assign greenCurrent = currents[1];
  assign blueCurrent  = currents[2];

endmodule

// File: tb/ledChainDriver_test.sv
module ledChainDriver_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shiftEn = 1'b0;
  logic        serIn = 1'b0;
  logic        latchIn = 1'b0;
  logic        cfgSel = 1'b0;
  logic        serOut, shiftEnOut, latchOut, cfgSelOut;
  logic [23:0] ledOn;
  logic [7:0]  redCurrent, greenCurrent, blueCurrent;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  bit done   = 0;
  logic [287:0] captured;

  // Stimulus table: {base, step}; channel p gets (base + p*step) mod 4096.
  localparam logic [23:0] VEC [5] = '{24'h000000, 24'hFFF000, 24'h0010AB,
                                      24'h800001, 24'hFA0003};

  ledChainDriver uut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .serIn(serIn), .latchIn(latchIn),
    .cfgSel(cfgSel), .serOut(serOut), .shiftEnOut(shiftEnOut), .latchOut(latchOut),
    .cfgSelOut(cfgSelOut), .ledOn(ledOn), .redCurrent(redCurrent),
    .greenCurrent(greenCurrent), .blueCurrent(blueCurrent)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  function automatic int phaseNow();
    return (edges - 1) % 4096;
  endfunction

  function automatic int slotNow();
    return (edges - 1) / 4096;
  endfunction

  function automatic logic [287:0] packGray(input int base, input int step);
    logic [287:0] f = '0;
    for (int p = 0; p < 24; p++) f[p*12 +: 12] = 12'((base + p*step) % 4096);
    return f;
  endfunction

  function automatic logic [287:0] cfgFrame(input int lvl, input int r, input int g, input int b);
    logic [287:0] f = '0;
    f[6:0] = 7'(lvl); f[15:8] = 8'(r); f[23:16] = 8'(g); f[31:24] = 8'(b);
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Shifts nBits of frame, highest index first; captures serOut after each shift.
  task automatic shiftFrame(input logic [287:0] frame, input int nBits);
    for (int i = nBits - 1; i >= 0; i--) begin
      serIn = frame[i];
      shiftEn = 1'b1;
      @(negedge clk);
      captured[nBits - 1 - i] = serOut;
    end
    shiftEn = 1'b0;
    serIn = 1'b0;
  endtask

  task automatic pulseLatch(input bit mode);
    cfgSel = mode;
    latchIn = 1'b1;
    @(negedge clk);
    latchIn = 1'b0;
    @(negedge clk);
    cfgSel = 1'b0;
  endtask

  // Compares all channels over one full PWM period against expected duty.
  task automatic pwmWindow(input logic [287:0] frame, input string req);
    int bad = 0; int badPort = 0; int act = 0; int exp = 0;
    while (phaseNow() != 0) @(negedge clk);
    for (int c = 0; c < 4096; c++) begin
      for (int p = 0; p < 24; p++) begin
        if (ledOn[p] !== (phaseNow() < int'(frame[p*12 +: 12]))) begin
          if (bad == 0) begin
            badPort = p; act = int'(ledOn[p]);
            exp = int'(phaseNow() < int'(frame[p*12 +: 12]));
          end
          bad++;
        end
      end
      @(negedge clk);
    end
    check(bad == 0, req, $sformatf("channel %0d duty mismatches=%0d first", badPort, bad), act, exp);
  endtask

  // Counts open brightness periods over 8 slots via channel 0 held at 4095.
  task automatic pdmSlots(input int lvl, input int expOn);
    int onCount = 0; int adjacent = 0; bit prevOn = 0; int s;
    shiftFrame(cfgFrame(lvl, 1, 2, 3), 288);
    pulseLatch(1'b1);
    s = slotNow() + 2;
    for (int k = 0; k < 8; k++) begin
      while (!(slotNow() == s + k && phaseNow() == 100)) @(negedge clk);
      if (ledOn[0]) begin
        onCount++;
        if (prevOn) adjacent++;
      end
      prevOn = ledOn[0];
      @(negedge clk);
    end
    check(onCount == expOn, "R7", $sformatf("open periods of 8 at level %0d", lvl), onCount, expOn);
    if (lvl == 64) check(adjacent == 0, "R9", "adjacent open periods at level 64", adjacent, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [287:0] frame, prevFrame, frameA, frameB;
    doReset();
    // R1: reset state at the ports
    check(ledOn == '0, "R1", "ledOn after reset", int'(ledOn), 0);
    check(serOut == 1'b0 && latchOut == 1'b0, "R1", "serial outputs after reset", int'(serOut), 0);
    check(redCurrent == 8'h80 && greenCurrent == 8'h80 && blueCurrent == 8'h80, "R1",
          "current codes after reset", int'({redCurrent, greenCurrent, blueCurrent}), 24'h808080);

    // R3/R6: table of grayscale patterns, boundaries 0 and 4095 included
    for (int v = 0; v < 5; v++) begin
      frame = packGray(int'(VEC[v][23:12]), int'(VEC[v][11:0]));
      shiftFrame(frame, 288);
      pulseLatch(1'b0);
      pwmWindow(frame, $sformatf("R6/R3 row %0d", v));
    end
    prevFrame = frame;

    // R4: partial and full shifting without a latch leaves outputs alone
    shiftFrame('0, 100);
    pwmWindow(prevFrame, "R4 partial shift");
    frame = packGray(5, 200);
    shiftFrame(frame, 288);
    pwmWindow(prevFrame, "R4 full shift no latch");
    pulseLatch(1'b0);
    pwmWindow(frame, "R4 latched frame");

    // R5: configuration load sets currents, keeps grayscale
    shiftFrame(cfgFrame(127, 8'h12, 8'h34, 8'h56), 288);
    pulseLatch(1'b1);
    check(redCurrent == 8'h12, "R5", "red current", int'(redCurrent), 8'h12);
    check(greenCurrent == 8'h34 && blueCurrent == 8'h56, "R5", "green/blue currents",
          int'({greenCurrent, blueCurrent}), 16'h3456);
    pwmWindow(frame, "R5 grayscale kept after config");
    frame = packGray(9, 77);
    shiftFrame(frame, 288);
    pulseLatch(1'b0);
    check({redCurrent, greenCurrent, blueCurrent} == 24'h123456, "R5",
          "currents kept after grayscale load", int'({redCurrent, greenCurrent, blueCurrent}), 24'h123456);

    // R2: bits leave serOut 288 strobes after entry, in entry order
    frameA = packGray(7, 333);
    frameB = packGray(1, 1);
    shiftFrame(frameA, 288);
    serIn = 1'b1; shiftEn = 1'b1;
    @(negedge clk);
    check(shiftEnOut == 1'b1, "R2", "shiftEnOut one clock later", int'(shiftEnOut), 1);
    shiftEn = 1'b0;
    @(negedge clk);
    check(shiftEnOut == 1'b0, "R2", "shiftEnOut follows low", int'(shiftEnOut), 0);
    // one extra bit went in: frameA shifted by one; realign by shifting B
    shiftFrame(frameB, 288);
    begin
      int bad = 0;
      for (int i = 0; i < 288; i++) begin
        logic expBit;
        expBit = (i == 287) ? 1'b1 : frameA[286 - i];
        if (captured[i] !== expBit) bad++;
      end
      check(bad == 0, "R2", "forwarded bit mismatches", bad, 0);
    end
    cfgSel = 1'b1; latchIn = 1'b1;
    @(negedge clk);
    check(latchOut == 1'b1 && cfgSelOut == 1'b1, "R2", "latch/mode forwarded",
          int'({latchOut, cfgSelOut}), 3);
    latchIn = 1'b0; cfgSel = 1'b0;
    @(negedge clk);

    // R7/R8/R9: brightness dither with every channel at 4095
    doReset();
    shiftFrame(packGray(4095, 0), 288);
    pulseLatch(1'b0);
    pdmSlots(64, 4);
    pdmSlots(96, 6);
    shiftFrame(cfgFrame(0, 0, 0, 0), 288);
    pulseLatch(1'b1);
    repeat (2) begin
      while (phaseNow() != 4000) @(negedge clk);
      @(negedge clk);
    end
    pwmWindow('0, "R8 level zero dark");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule